// File: doc/BRIEF.md
# Two-Channel PWM Compare and Action Qualifier

This block turns a free-running time-base count and its events into two pulse-width-modulated outputs, A and B. Each channel owns a compare register. A compare value can take effect at once, or it can wait in a shadow copy until a selectable load point in the counting cycle. Each compare register is matched against the count while the count runs upward.

For each output a small action table gives the response to three events: counter zero, compare-A match while counting up, and compare-B match while counting up. The response can be to do nothing, drive low, drive high or toggle. A continuous force field per channel can pin an output low or high. The generated waveform keeps evolving underneath the force and shows again once the force is released.

The block sits after a time-base counter. The counter supplies the count value, the zero and period events and the count direction. The static configuration is held on input vectors whose field positions follow the register layout given below.

Top module: `pwm_aq_top`

## Requirements
- R1: After reset both outputs are low and both active compare values are 0.
- R2: When a channel's shadow-enable bit is 0, a write to its compare register shows on `cmp_act_o` one cycle later. The shadow-enable bit is bit 4 of `cmp_ctl_i` for channel A and bit 6 for channel B.
- R3: When the shadow-enable bit is 1, a write goes into the shadow copy only. The active value takes the shadow value at the load point chosen by the 2-bit field, which is `cmp_ctl_i[1:0]` for A and `cmp_ctl_i[3:2]` for B. Code 0 loads on a counter-zero event, code 1 loads on a period event and code 2 loads on either event. Between load points the active value does not change.
- R4: With shadow enabled and load-point code 3, the active compare value stays frozen, even when new values are written.
- R5: Action codes are 0 none, 1 low, 2 high and 3 toggle. In the 10-bit action field of each output (`aq_ctl_i[9:0]` for A, `[19:10]` for B), bits 1:0 give the zero action, bits 5:4 the compare-A-up action and bits 9:8 the compare-B-up action. The output reflects an action one cycle after its event.
- R6: A compare match happens only while `cnt_up_i` is 1 and the count equals the active compare value. While counting down, the compare actions have no effect.
- R7: When several events with non-zero actions coincide, the compare-B action wins over the compare-A action, and the compare-A action wins over the zero action.
- R8: With set-at-zero and clear-at-compare-A, an active compare value of 0 gives a constant low output.
- R9: The force field is `force_i[1:0]` for A and `[3:2]` for B. Code 1 holds the output low and code 2 holds it high, from the cycle after the code is applied. Codes 0 and 3 apply no force. The underlying waveform keeps running while forced.
- R10: Normal polarity (zero sets the output, the compare match clears it) and inverted polarity (zero clears, the compare match sets) give complementary pulse shapes of the programmed width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_i | input | CNT_W | Time-base count value |
| zero_evt_i | input | 1 | Counter-zero event |
| prd_evt_i | input | 1 | Period-match event |
| cnt_up_i | input | 1 | 1 while the counter counts upward |
| cmp_wr_i | input | 2 | Compare write strobe, bit 0 channel A, bit 1 channel B |
| cmp_data_i | input | 2*CNT_W | Compare write data, A in the low half |
| cmp_ctl_i | input | 7 | Load-point fields [1:0] A and [3:2] B; shadow-enable bits 4 (A) and 6 (B) |
| aq_ctl_i | input | 20 | Action fields, A in [9:0], B in [19:10] |
| force_i | input | 4 | Continuous force codes, A in [1:0], B in [3:2] |
| pwm_o | output | 2 | Registered PWM outputs, bit 0 A, bit 1 B |
| cmp_act_o | output | 2*CNT_W | Active compare values, A in the low half |

## Verification
A corrupted active compare value appears directly on `cmp_act_o` in the cycle after the bad load. It also moves the output edge within the same counting period. A wrong shadow copy stays hidden until the next load point, so the bench writes mid-period and keeps watching through several zero and period events. A wrong waveform state bit shows on `pwm_o` one cycle after it forms, except while a force masks it. For that reason the bench releases every force and compares the output that comes back.

// File: rtl/pwm_aq_pkg.sv
`timescale 1ns/1ps
package pwm_aq_pkg;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_LOW    = 2'd1,
        ACT_HIGH   = 2'd2,
        ACT_TOGGLE = 2'd3
    } act_e;

    typedef enum logic [1:0] {
        FRC_OFF  = 2'd0,
        FRC_LOW  = 2'd1,
        FRC_HIGH = 2'd2,
        FRC_ALT  = 2'd3
    } frc_e;

    typedef enum logic [1:0] {
        LD_ZERO   = 2'd0,
        LD_PRD    = 2'd1,
        LD_EITHER = 2'd2,
        LD_FREEZE = 2'd3
    } ld_e;

    localparam int unsigned NUM_CH     = 2;
    localparam int unsigned AQ_W       = 10;
    localparam int unsigned CMP_CTL_W  = 7;
    localparam int unsigned SHD_BIT0   = 4;
    localparam int unsigned FRC_W      = 2;

    typedef struct packed {
        logic aq;
        logic pwm;
    } qual_state_t;

    function automatic logic act_apply(act_e a, logic cur);
        logic r;
        case (a)
            ACT_LOW:    r = 1'b0;
            ACT_HIGH:   r = 1'b1;
            ACT_TOGGLE: r = ~cur;
            default:    r = cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pwm_aq_cmp.sv
`timescale 1ns/1ps
module pwm_aq_cmp
    import pwm_aq_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] data_i,
    input  logic             shadow_en_i,
    input  logic [1:0]       load_sel_i,
    input  logic             zero_evt_i,
    input  logic             prd_evt_i,
    output logic [CNT_W-1:0] act_o
);

    typedef struct packed {
        logic [CNT_W-1:0] act;
        logic [CNT_W-1:0] shd;
    } cmp_state_t;

    cmp_state_t s_d, s_q;
    logic       load_pt;

    always_comb begin
        case (ld_e'(load_sel_i))
            LD_ZERO:   load_pt = zero_evt_i;
            LD_PRD:    load_pt = prd_evt_i;
            LD_EITHER: load_pt = zero_evt_i | prd_evt_i;
            default:   load_pt = 1'b0;
        endcase
    end

    always_comb begin
        s_d = s_q;
        if (shadow_en_i && load_pt) begin
            s_d.act = s_q.shd;
        end
        if (wr_i) begin
            if (shadow_en_i) begin
                s_d.shd = data_i;
            end else begin
                s_d.act = data_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign act_o = s_q.act;

endmodule

// File: rtl/pwm_aq_qual.sv
`timescale 1ns/1ps
module pwm_aq_qual
    import pwm_aq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AQ_W-1:0] ctl_i,
    input  logic            zero_evt_i,
    input  logic            cau_i,
    input  logic            cbu_i,
    input  logic [1:0]      force_i,
    output logic            pwm_o
);

    qual_state_t s_d, s_q;
    act_e        act_zero, act_cau, act_cbu, act_sel;
    logic        unused_ctl;

    assign act_zero   = act_e'(ctl_i[1:0]);
    assign act_cau    = act_e'(ctl_i[5:4]);
    assign act_cbu    = act_e'(ctl_i[9:8]);
    assign unused_ctl = ^{ctl_i[3:2], ctl_i[7:6]};

    // Later assignments carry higher priority: compare B, then A, then zero.
    always_comb begin
        act_sel = ACT_NONE;
        if (zero_evt_i && act_zero != ACT_NONE) act_sel = act_zero;
        if (cau_i      && act_cau  != ACT_NONE) act_sel = act_cau;
        if (cbu_i      && act_cbu  != ACT_NONE) act_sel = act_cbu;
    end

    always_comb begin
        s_d    = s_q;
        s_d.aq = act_apply(act_sel, s_q.aq);
        case (frc_e'(force_i))
            FRC_LOW:  s_d.pwm = 1'b0;
            FRC_HIGH: s_d.pwm = 1'b1;
            default:  s_d.pwm = s_d.aq;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pwm_o = s_q.pwm;

endmodule

// File: rtl/pwm_aq_top.sv
`timescale 1ns/1ps
module pwm_aq_top
    import pwm_aq_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CNT_W-1:0]         cnt_i,
    input  logic                     zero_evt_i,
    input  logic                     prd_evt_i,
    input  logic                     cnt_up_i,
    input  logic [NUM_CH-1:0]        cmp_wr_i,
    input  logic [NUM_CH*CNT_W-1:0]  cmp_data_i,
    input  logic [CMP_CTL_W-1:0]     cmp_ctl_i,
    input  logic [NUM_CH*AQ_W-1:0]   aq_ctl_i,
    input  logic [NUM_CH*FRC_W-1:0]  force_i,
    output logic [NUM_CH-1:0]        pwm_o,
    output logic [NUM_CH*CNT_W-1:0]  cmp_act_o
);

    logic [NUM_CH-1:0] match_up;
    logic              unused_ctl;

    assign unused_ctl = cmp_ctl_i[SHD_BIT0+1];

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cmp
        logic [CNT_W-1:0] act;

        pwm_aq_cmp #(.CNT_W(CNT_W)) u_cmp (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_i        (cmp_wr_i[ch]),
            .data_i      (cmp_data_i[ch*CNT_W +: CNT_W]),
            .shadow_en_i (cmp_ctl_i[SHD_BIT0 + 2*ch]),
            .load_sel_i  (cmp_ctl_i[2*ch +: 2]),
            .zero_evt_i  (zero_evt_i),
            .prd_evt_i   (prd_evt_i),
            .act_o       (act)
        );

        assign match_up[ch]                    = cnt_up_i && (cnt_i == act);
        assign cmp_act_o[ch*CNT_W +: CNT_W]    = act;
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_qual
        pwm_aq_qual u_qual (
            .clk        (clk),
            .rst_n      (rst_n),
            .ctl_i      (aq_ctl_i[ch*AQ_W +: AQ_W]),
            .zero_evt_i (zero_evt_i),
            .cau_i      (match_up[0]),
            .cbu_i      (match_up[1]),
            .force_i    (force_i[ch*FRC_W +: FRC_W]),
            .pwm_o      (pwm_o[ch])
        );
    end

endmodule

// File: rtl/pwm_aq_chk.sv
`timescale 1ns/1ps
module pwm_aq_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               zero_evt_i,
    input logic               prd_evt_i,
    input logic               cnt_up_i,
    input logic [1:0]         cmp_wr_i,
    input logic [2*CNT_W-1:0] cmp_data_i,
    input logic [6:0]         cmp_ctl_i,
    input logic [3:0]         force_i,
    input logic [1:0]         pwm_o,
    input logic [2*CNT_W-1:0] cmp_act_o
);

    logic unused_bit;
    assign unused_bit = cmp_ctl_i[5];

    assert_imm_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_wr_i[0] && !cmp_ctl_i[4]) |=> cmp_act_o[CNT_W-1:0] == $past(cmp_data_i[CNT_W-1:0]));

    assert_imm_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_wr_i[1] && !cmp_ctl_i[6]) |=> cmp_act_o[2*CNT_W-1:CNT_W] == $past(cmp_data_i[2*CNT_W-1:CNT_W]));

    assert_shadow_hold_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_ctl_i[4] && !zero_evt_i && !prd_evt_i) |=> $stable(cmp_act_o[CNT_W-1:0]));

    assert_shadow_hold_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_ctl_i[6] && !zero_evt_i && !prd_evt_i) |=> $stable(cmp_act_o[2*CNT_W-1:CNT_W]));

    assert_freeze_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_ctl_i[4] && cmp_ctl_i[1:0] == 2'd3) |=> $stable(cmp_act_o[CNT_W-1:0]));

    assert_force_low_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (force_i[1:0] == 2'd1) |=> !pwm_o[0]);

    assert_force_high_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (force_i[1:0] == 2'd2) |=> pwm_o[0]);

    assert_force_low_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (force_i[3:2] == 2'd1) |=> !pwm_o[1]);

    assert_force_high_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (force_i[3:2] == 2'd2) |=> pwm_o[1]);

    // R6: with no zero event and counting down, no action can fire.
    assert_quiet_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(force_i[1:0]) == 2'd0 && force_i[1:0] == 2'd0 && !zero_evt_i && !cnt_up_i)
        |=> $stable(pwm_o[0]));

    assert_quiet_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(force_i[3:2]) == 2'd0 && force_i[3:2] == 2'd0 && !zero_evt_i && !cnt_up_i)
        |=> $stable(pwm_o[1]));

endmodule

bind pwm_aq_top pwm_aq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .zero_evt_i (zero_evt_i),
    .prd_evt_i  (prd_evt_i),
    .cnt_up_i   (cnt_up_i),
    .cmp_wr_i   (cmp_wr_i),
    .cmp_data_i (cmp_data_i),
    .cmp_ctl_i  (cmp_ctl_i),
    .force_i    (force_i),
    .pwm_o      (pwm_o),
    .cmp_act_o  (cmp_act_o)
);

// File: tb/pwm_aq_top_tb.sv
`timescale 1ns/1ps
module pwm_aq_top_tb;

    localparam int CW  = 16;
    localparam int PER = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] cnt = '0;
    logic          zero = 1'b0, prd = 1'b0, up = 1'b0;
    logic [1:0]    cmp_wr = '0;
    logic [2*CW-1:0] cmp_data = '0;
    logic [6:0]    cmp_ctl = '0;
    logic [19:0]   aq_ctl = '0;
    logic [3:0]    frc = '0;
    logic [1:0]    pwm;
    logic [2*CW-1:0] cmp_act;

    int checks = 0;
    int failures = 0;
    int c = 0;
    bit done = 0;

    typedef struct {
        logic [1:0]      pwm;
        logic [2*CW-1:0] cmp;
        string           tag;
    } exp_t;
    exp_t q[$];

    // expectation model state
    logic [CW-1:0] m_act [2];
    logic [CW-1:0] m_shd [2];
    logic          m_aq  [2];
    logic          m_out [2];

    always #10 clk = ~clk;

    pwm_aq_top #(.CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .zero_evt_i(zero), .prd_evt_i(prd),
        .cnt_up_i(up), .cmp_wr_i(cmp_wr), .cmp_data_i(cmp_data), .cmp_ctl_i(cmp_ctl),
        .aq_ctl_i(aq_ctl), .force_i(frc), .pwm_o(pwm), .cmp_act_o(cmp_act)
    );

    task automatic model_edge();
        logic ca, cb;
        ca = up && (cnt == m_act[0]);
        cb = up && (cnt == m_act[1]);
        for (int ch = 0; ch < 2; ch++) begin
            logic [9:0] f;
            logic [1:0] code;
            logic [1:0] fc;
            logic       shen, ld;
            logic [1:0] sel;
            f = aq_ctl[ch*10 +: 10];
            code = 2'd0;
            if (zero && f[1:0] != 0) code = f[1:0];
            if (ca && f[5:4] != 0)   code = f[5:4];
            if (cb && f[9:8] != 0)   code = f[9:8];
            if (code == 2'd1) m_aq[ch] = 1'b0;
            else if (code == 2'd2) m_aq[ch] = 1'b1;
            else if (code == 2'd3) m_aq[ch] = ~m_aq[ch];
            fc = frc[2*ch +: 2];
            m_out[ch] = (fc == 2'd1) ? 1'b0 : (fc == 2'd2) ? 1'b1 : m_aq[ch];
            shen = cmp_ctl[4 + 2*ch];
            sel  = cmp_ctl[2*ch +: 2];
            ld = shen && ((sel == 0 && zero) || (sel == 1 && prd) || (sel == 2 && (zero || prd)));
            if (ld) m_act[ch] = m_shd[ch];
            if (cmp_wr[ch]) begin
                if (shen) m_shd[ch] = cmp_data[ch*CW +: CW];
                else      m_act[ch] = cmp_data[ch*CW +: CW];
            end
        end
    endtask

    // Driver: inputs are set at a falling edge; expectation for the next rising edge is queued.
    task automatic tick(string tag);
        exp_t e;
        model_edge();
        e.pwm = {m_out[1], m_out[0]};
        e.cmp = {m_act[1], m_act[0]};
        e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        cmp_wr = '0;
    endtask

    task automatic run_up(int n, string tag);
        for (int i = 0; i < n; i++) begin
            up = 1'b1;
            cnt = CW'(c);
            zero = (c == 0);
            prd = (c == PER - 1);
            tick(tag);
            c = (c == PER - 1) ? 0 : c + 1;
        end
    endtask

    task automatic run_down(int n, string tag);
        for (int i = 0; i < n; i++) begin
            up = 1'b0;
            cnt = CW'(c);
            zero = (c == 0);
            prd = (c == PER - 1);
            tick(tag);
            c = (c == 0) ? PER - 1 : c - 1;
        end
    endtask

    task automatic write_cmp(logic [1:0] which, logic [CW-1:0] a, logic [CW-1:0] b);
        cmp_wr = which;
        cmp_data = {b, a};
    endtask

    // Monitor: pops one expectation per rising edge and compares away from the edge.
    always @(posedge clk) begin
        #5;
        if (rst_n && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (pwm !== e.pwm || cmp_act !== e.cmp) begin
                failures++;
                $display("FAIL %s pwm=%b cmp=%h expected pwm=%b cmp=%h",
                         e.tag, pwm, cmp_act, e.pwm, e.cmp);
            end
        end
    end

    initial begin
        #4000000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int ch = 0; ch < 2; ch++) begin
            m_act[ch] = '0; m_shd[ch] = '0; m_aq[ch] = 1'b0; m_out[ch] = 1'b0;
        end
        repeat (4) @(negedge clk);
        // R1: reset state
        checks++;
        if (pwm !== 2'b00 || cmp_act !== '0) begin
            failures++;
            $display("FAIL R1 pwm=%b cmp=%h expected pwm=00 cmp=0", pwm, cmp_act);
        end
        rst_n = 1'b1;

        // R10 and R2: A normal polarity width 3, B inverted width 5, immediate writes
        aq_ctl = {10'h201, 10'h012};
        cmp_ctl = 7'h00;
        write_cmp(2'b11, 16'd3, 16'd5);
        run_up(24, "R10");

        // R2: immediate rewrite of A alone
        write_cmp(2'b01, 16'd6, 16'd0);
        run_up(10, "R2");

        // R7: A sets on zero, sets on CA, clears on CB; coincident matches at 4
        aq_ctl = {10'h201, 10'h122};
        write_cmp(2'b11, 16'd4, 16'd4);
        run_up(16, "R7");

        // R8: zero compare on A with set-at-zero, clear-at-CA
        aq_ctl = {10'h201, 10'h012};
        write_cmp(2'b01, 16'd0, 16'd4);
        run_up(16, "R8");

        // R5: A toggles on zero, B toggles on the CA match
        aq_ctl = {10'h030, 10'h003};
        write_cmp(2'b01, 16'd2, 16'd4);
        run_up(20, "R5");

        // R9: force A low and B high, then A high and B with code 3, then release
        frc = 4'b1001;
        run_up(10, "R9");
        frc = 4'b1110;
        run_up(10, "R9");
        frc = 4'b0000;
        run_up(10, "R9");

        // R3: shadow on both, A loads at zero, B at period; write mid-period
        aq_ctl = {10'h201, 10'h012};
        cmp_ctl = 7'h54;
        run_up(3, "R3");
        write_cmp(2'b11, 16'd6, 16'd2);
        run_up(14, "R3");
        // R3: A loads on either event
        cmp_ctl = 7'h56;
        run_up(2, "R3");
        write_cmp(2'b01, 16'd1, 16'd0);
        run_up(12, "R3");

        // R4: freeze A; new writes must not reach the active value
        cmp_ctl = 7'h57;
        write_cmp(2'b01, 16'd7, 16'd0);
        run_up(16, "R4");

        // R6: counting down, compare actions are ignored
        cmp_ctl = 7'h00;
        write_cmp(2'b11, 16'd3, 16'd5);
        run_up(1, "R6");
        run_down(20, "R6");

        repeat (3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule